// File: doc/BRIEF.md
# Serial Port Pin Multiplexer with General-Purpose I/O

This block stands between a queued SPI engine, a set of SCI transmit/receive pairs and the chip pads. A small register bus holds three things: a port data value, a per-pin direction mask and a per-pin SPI assignment mask. For each pad the block decides who owns it: the SPI engine, an SCI channel, or general-purpose I/O. It also decides whether the pad drives or is only sampled. In SPI use the direction bit means something different for each pin, and its meaning also depends on master or slave mode. A direction bit can choose between input and disabled on one pin and between output and disabled on another.

Pads are numbered with the SPI pins first and the SCI pins after them. MISO is 0, MOSI is 1, SCK is 2, and PCS0/SS is 3. PCS1..PCS(NPCS-1) follow from 4. Then each SCI channel c takes two pins: TXD at 3+NPCS+2c and RXD at 4+NPCS+2c. With the defaults (four chip selects, two SCI channels) there are 11 pads, indices 0 to 10. Pad levels pass through a two-flop synchronizer. The result feeds the port read-back and mode-fault detection. When the engine samples the pad as a data, clock or select input, it receives the level directly. A slave select driven low while the pin is an SPI input in master mode sets a sticky mode-fault flag.

The block carries no data stream of its own, so it has no valid/ready interfaces. The register bus is a single-cycle write strobe with a combinational read. The bus can never stall, and every engine and pad signal is plain level control.

Top module: `qsm_portmux`

## Requirements
- R1: After reset the direction register and assignment register read 0, every pad_oe bit is 0, every pad_out bit is 0, and mode_fault is 0.
- R2: A pad not claimed by SPI or SCI is GPIO. pad_oe equals its direction bit (1 = output). pad_out equals the port data bit when driving, and 0 when not driving. Writing port data therefore changes only output pads.
- R3: Reading address 0 returns the level on every pad after two rising clock edges, whatever the pad's direction or owner. After only one edge, the old level is still returned.
- R4: MISO (pad 0) in SPI use never drives in master mode. There it feeds spi_miso_i from the pad when direction is 0, and holds spi_miso_i at 0 when direction is 1. In slave mode it drives spi_miso_o when direction is 1 and floats when direction is 0.
- R5: MOSI (pad 1) in SPI use drives spi_mosi_o in master mode when direction is 1, and floats when direction is 0. In slave mode it never drives, and spi_mosi_i follows the pad when direction is 0 and is 0 when direction is 1.
- R6: SCK (pad 2) has no assignment bit. It is GPIO while spi_en is 0. While spi_en is 1 it ignores its direction bit: in master mode it drives spi_sck_o, and in slave mode it does not drive and spi_sck_i follows the pad.
- R7: PCS0/SS (pad 3) in SPI master use drives spi_pcs_o[0] when direction is 1. When direction is 0 it does not drive and spi_ss_n_i stays 1.
- R8: PCS0/SS in slave mode never drives. spi_ss_n_i follows the pad when direction is 0 and is forced to 1 when direction is 1.
- R9: PCS1..PCS(NPCS-1) in SPI use drive spi_pcs_o[k] in master mode when direction is 1. They are off when direction is 0, and always off in slave mode.
- R10: While sci_tx_en[c] is 1, the TXD pad drives sci_txd[c] regardless of direction. While sci_rx_en[c] is 1, the RXD pad does not drive and sci_rxd[c] follows the pad. A disabled channel's pads fall back to GPIO, and a disabled receiver presents sci_rxd[c] = 1.
- R11: mode_fault becomes 1 on the clock edge after the synchronized PCS0/SS level is 0 while spi_en, master mode and assignment bit 3 are 1 and direction bit 3 is 0. It stays 1 until bus_wdata[0] = 1 is written to address 3, which clears it. If a set and a clear fall in the same cycle, the set wins. Address 3 reads the flag in bit 0.
- R12: Register map: address 0 is port data (write) and pad levels (read), address 1 is direction, address 2 is SPI assignment, and address 3 is status. The assignment register implements bits 0, 1 and 3..NPCS+2. Bit 2 and all higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| spi_en | input | 1 | SPI engine enabled |
| spi_master | input | 1 | 1 = master, 0 = slave |
| spi_mosi_o | input | 1 | Engine master data out |
| spi_miso_o | input | 1 | Engine slave data out |
| spi_sck_o | input | 1 | Engine serial clock out |
| spi_pcs_o | input | NPCS | Engine chip selects |
| spi_mosi_i | output | 1 | Slave data in to engine |
| spi_miso_i | output | 1 | Master data in to engine |
| spi_sck_i | output | 1 | Slave clock in to engine |
| spi_ss_n_i | output | 1 | Slave select in to engine, active low |
| sci_tx_en | input | NSCI | Per-channel transmitter enable |
| sci_txd | input | NSCI | Per-channel transmit data |
| sci_rx_en | input | NSCI | Per-channel receiver enable |
| sci_rxd | output | NSCI | Per-channel receive data |
| mode_fault | output | 1 | Sticky mode-fault flag |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad output enables |

## Verification
The bench sweeps master, slave and disabled SPI states against the direction and assignment masks. A design that read a direction bit with the meaning of another pin would drive MISO in master mode or MOSI in slave mode, and the sweep would show the extra enable. SCK is tested with direction 0 under SPI master use: a design that let direction govern SCK would leave the clock pad floating. The synchronizer depth is checked one edge early, which catches both a missing stage and an extra one. The fault flag is checked on the exact setting edge, after the pad returns high (a non-sticky flag would drop), and with direction 1 holding the pad low (a design that ignored the direction bit would raise a false fault).

// File: rtl/qsm_pkg.sv
package qsm_pkg;

  typedef enum logic [1:0] {
    SEL_PORT   = 2'd0,
    SEL_DIR    = 2'd1,
    SEL_ASSIGN = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;

  function automatic int sci_tx_pin(input int npcs, input int ch);
    return 3 + npcs + 2 * ch;
  endfunction

  function automatic int sci_rx_pin(input int npcs, input int ch);
    return 4 + npcs + 2 * ch;
  endfunction

endpackage

// File: rtl/qsm_sync.sv
module qsm_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/qsm_regs.sv
module qsm_regs
  import qsm_pkg::*;
#(
  parameter int NPIN = 11,
  parameter int NSPI = 7,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_sync,
  input  logic            fault_q,
  output logic [NPIN-1:0] port_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NSPI-1:0] asg_q,
  output logic            fault_clr
);
  localparam logic [NSPI-1:0] ASG_MASK = {NSPI{1'b1}} & ~(NSPI'(1) << PIN_SCK);

  logic hit_port, hit_dir, hit_asg, hit_stat;

  always_comb begin
    hit_port = bus_wr && (bus_addr == AW'(SEL_PORT));
    hit_dir  = bus_wr && (bus_addr == AW'(SEL_DIR));
    hit_asg  = bus_wr && (bus_addr == AW'(SEL_ASSIGN));
    hit_stat = bus_wr && (bus_addr == AW'(SEL_STAT));
  end

  assign fault_clr = hit_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      dir_q  <= '0;
      asg_q  <= '0;
    end else begin
      if (hit_port) port_q <= bus_wdata[NPIN-1:0];
      if (hit_dir)  dir_q  <= bus_wdata[NPIN-1:0];
      if (hit_asg)  asg_q  <= bus_wdata[NSPI-1:0] & ASG_MASK;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(SEL_PORT):   bus_rdata[NPIN-1:0] = pin_sync;
      AW'(SEL_DIR):    bus_rdata[NPIN-1:0] = dir_q;
      AW'(SEL_ASSIGN): bus_rdata[NSPI-1:0] = asg_q;
      default:         bus_rdata[0]        = fault_q;
    endcase
  end
endmodule

// File: rtl/qsm_pinmux.sv
module qsm_pinmux
  import qsm_pkg::*;
#(
  parameter int NPCS = 4,
  parameter int NSCI = 2,
  parameter int NPIN = 3 + NPCS + 2 * NSCI,
  parameter int NSPI = 3 + NPCS
) (
  input  logic            spi_en,
  input  logic            spi_master,
  input  logic            spi_mosi_o,
  input  logic            spi_miso_o,
  input  logic            spi_sck_o,
  input  logic [NPCS-1:0] spi_pcs_o,
  output logic            spi_mosi_i,
  output logic            spi_miso_i,
  output logic            spi_sck_i,
  output logic            spi_ss_n_i,
  input  logic [NSCI-1:0] sci_tx_en,
  input  logic [NSCI-1:0] sci_txd,
  input  logic [NSCI-1:0] sci_rx_en,
  output logic [NSCI-1:0] sci_rxd,
  input  logic [NPIN-1:0] port_q,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NSPI-1:0] asg_q,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            ss_fault_arm
);
  logic [NPIN-1:0] raw_out;
  logic [NSPI-1:0] spi_own;

  always_comb begin
    spi_own          = {NSPI{spi_en}} & asg_q;
    spi_own[PIN_SCK] = spi_en;
  end

  always_comb begin
    raw_out      = port_q;
    pad_oe       = dir_q;
    spi_miso_i   = 1'b0;
    spi_mosi_i   = 1'b0;
    spi_sck_i    = 1'b0;
    spi_ss_n_i   = 1'b1;
    ss_fault_arm = 1'b0;

    if (spi_own[PIN_MISO]) begin
      raw_out[PIN_MISO] = spi_miso_o;
      pad_oe[PIN_MISO]  = !spi_master && dir_q[PIN_MISO];
      spi_miso_i        = spi_master && !dir_q[PIN_MISO] && pad_in[PIN_MISO];
    end

    if (spi_own[PIN_MOSI]) begin
      raw_out[PIN_MOSI] = spi_mosi_o;
      pad_oe[PIN_MOSI]  = spi_master && dir_q[PIN_MOSI];
      spi_mosi_i        = !spi_master && !dir_q[PIN_MOSI] && pad_in[PIN_MOSI];
    end

    if (spi_own[PIN_SCK]) begin
      raw_out[PIN_SCK] = spi_sck_o;
      pad_oe[PIN_SCK]  = spi_master;
      spi_sck_i        = !spi_master && pad_in[PIN_SCK];
    end

    if (spi_own[PIN_SS]) begin
      raw_out[PIN_SS] = spi_pcs_o[0];
      if (spi_master) begin
        pad_oe[PIN_SS] = dir_q[PIN_SS];
        ss_fault_arm   = !dir_q[PIN_SS];
      end else begin
        pad_oe[PIN_SS] = 1'b0;
        spi_ss_n_i     = dir_q[PIN_SS] || pad_in[PIN_SS];
      end
    end

    for (int k = 1; k < NPCS; k++) begin
      if (spi_own[PIN_SS + k]) begin
        raw_out[PIN_SS + k] = spi_pcs_o[k];
        pad_oe[PIN_SS + k]  = spi_master && dir_q[PIN_SS + k];
      end
    end

    for (int c = 0; c < NSCI; c++) begin
      sci_rxd[c] = 1'b1;
      if (sci_tx_en[c]) begin
        raw_out[sci_tx_pin(NPCS, c)] = sci_txd[c];
        pad_oe[sci_tx_pin(NPCS, c)]  = 1'b1;
      end
      if (sci_rx_en[c]) begin
        pad_oe[sci_rx_pin(NPCS, c)] = 1'b0;
        sci_rxd[c]                  = pad_in[sci_rx_pin(NPCS, c)];
      end
    end
  end

  assign pad_out = raw_out & pad_oe;
endmodule

// File: rtl/qsm_fault.sv
module qsm_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ss_sync,
  input  logic clr,
  output logic fault_q
);
  logic set_now;

  assign set_now = arm && !ss_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= set_now || (fault_q && !clr);
  end
endmodule

// File: rtl/qsm_portmux.sv
module qsm_portmux
  import qsm_pkg::*;
#(
  parameter  int NPCS = 4,
  parameter  int NSCI = 2,
  parameter  int DW   = 16,
  parameter  int AW   = 2,
  localparam int NPIN = 3 + NPCS + 2 * NSCI,
  localparam int NSPI = 3 + NPCS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            spi_en,
  input  logic            spi_master,
  input  logic            spi_mosi_o,
  input  logic            spi_miso_o,
  input  logic            spi_sck_o,
  input  logic [NPCS-1:0] spi_pcs_o,
  output logic            spi_mosi_i,
  output logic            spi_miso_i,
  output logic            spi_sck_i,
  output logic            spi_ss_n_i,
  input  logic [NSCI-1:0] sci_tx_en,
  input  logic [NSCI-1:0] sci_txd,
  input  logic [NSCI-1:0] sci_rx_en,
  output logic [NSCI-1:0] sci_rxd,
  output logic            mode_fault,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] port_q;
  logic [NPIN-1:0] dir_q;
  logic [NSPI-1:0] asg_q;
  logic            fault_clr;
  logic            ss_fault_arm;
  logic            ss_sync;

  assign ss_sync = pin_sync[PIN_SS];

  qsm_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  qsm_regs #(.NPIN(NPIN), .NSPI(NSPI), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .fault_q   (mode_fault),
    .port_q    (port_q),
    .dir_q     (dir_q),
    .asg_q     (asg_q),
    .fault_clr (fault_clr)
  );

  qsm_pinmux #(.NPCS(NPCS), .NSCI(NSCI), .NPIN(NPIN), .NSPI(NSPI)) u_mux (
    .spi_en       (spi_en),
    .spi_master   (spi_master),
    .spi_mosi_o   (spi_mosi_o),
    .spi_miso_o   (spi_miso_o),
    .spi_sck_o    (spi_sck_o),
    .spi_pcs_o    (spi_pcs_o),
    .spi_mosi_i   (spi_mosi_i),
    .spi_miso_i   (spi_miso_i),
    .spi_sck_i    (spi_sck_i),
    .spi_ss_n_i   (spi_ss_n_i),
    .sci_tx_en    (sci_tx_en),
    .sci_txd      (sci_txd),
    .sci_rx_en    (sci_rx_en),
    .sci_rxd      (sci_rxd),
    .port_q       (port_q),
    .dir_q        (dir_q),
    .asg_q        (asg_q),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .ss_fault_arm (ss_fault_arm)
  );

  qsm_fault u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (ss_fault_arm),
    .ss_sync (ss_sync),
    .clr     (fault_clr),
    .fault_q (mode_fault)
  );
endmodule

// File: rtl/qsm_portmux_chk.sv
module qsm_portmux_chk #(
  parameter int NPIN = 11,
  parameter int NSPI = 7,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            spi_en,
  input logic            spi_master,
  input logic            tx0_en,
  input logic [NPIN-1:0] dir_q,
  input logic [NSPI-1:0] asg_q,
  input logic            ss_sync,
  input logic            mode_fault,
  input logic [NPIN-1:0] pad_oe
);
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master && asg_q[3] && !dir_q[3] && !ss_sync) |=> mode_fault); // R11

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !(bus_wr && bus_addr == AW'(3) && bus_wdata[0])) |=> mode_fault); // R11

  AST_MISO_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master && asg_q[0]) |-> !pad_oe[0]); // R4

  AST_MOSI_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master && asg_q[1]) |-> !pad_oe[1]); // R5

  AST_SCK_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> !pad_oe[2]); // R6

  AST_SCK_MASTER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> pad_oe[2]); // R6

  AST_PCS_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> ((pad_oe[NSPI-1:3] & asg_q[NSPI-1:3]) == '0)); // R9

  AST_GPIO_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_en && !dir_q[0]) |-> !pad_oe[0]); // R2

  AST_TXD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    tx0_en |-> pad_oe[NSPI]); // R10
endmodule

bind qsm_portmux qsm_portmux_chk #(.NPIN(NPIN), .NSPI(NSPI), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .spi_en     (spi_en),
  .spi_master (spi_master),
  .tx0_en     (sci_tx_en[0]),
  .dir_q      (dir_q),
  .asg_q      (asg_q),
  .ss_sync    (ss_sync),
  .mode_fault (mode_fault),
  .pad_oe     (pad_oe)
);

// File: tb/sim_qsm_portmux.sv
module sim_qsm_portmux;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 11;
  localparam int NVEC = 8;

  // {spi_en, master, assign[6:0], dir[6:0], expected pad_oe[6:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 7'h7B, 7'h7F, 7'h7F},
    {1'b1, 1'b1, 7'h7B, 7'h00, 7'h04},
    {1'b1, 1'b1, 7'h7B, 7'h7F, 7'h7E},
    {1'b1, 1'b0, 7'h7B, 7'h00, 7'h00},
    {1'b1, 1'b0, 7'h7B, 7'h7F, 7'h01},
    {1'b1, 1'b1, 7'h00, 7'h00, 7'h04},
    {1'b1, 1'b0, 7'h00, 7'h55, 7'h51},
    {1'b1, 1'b1, 7'h01, 7'h7F, 7'h7E}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic            spi_en = 1'b0, spi_master = 1'b0;
  logic            spi_mosi_o = 1'b1, spi_miso_o = 1'b1, spi_sck_o = 1'b1;
  logic [3:0]      spi_pcs_o = 4'b1111;
  logic            spi_mosi_i, spi_miso_i, spi_sck_i, spi_ss_n_i;
  logic [1:0]      sci_tx_en = '0, sci_txd = '0, sci_rx_en = '0;
  logic [1:0]      sci_rxd;
  logic            mode_fault;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rv;

  qsm_portmux u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(2'd1, rv); check("R1 dir", rv, 0);
    rd(2'd2, rv); check("R1 assign", rv, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_out", pad_out, 0);
    check("R1 fault", mode_fault, 0);

    // R2 GPIO: output only where dir=1
    wr(2'd0, 16'h07FF);
    check("R2 out dir0", pad_out, 0);
    wr(2'd1, 16'h00F0);
    check("R2 oe", pad_oe, 11'h0F0);
    check("R2 out", pad_out, 11'h0F0);
    wr(2'd0, 16'h0550);
    check("R2 out pattern", pad_out, 11'h050);

    // R3 synchronizer depth
    @(negedge clk); pad_in = 11'h2A5;
    edges(1); rd(2'd0, rv); check("R3 one edge", rv, 0);
    edges(1); rd(2'd0, rv); check("R3 two edges", rv, 11'h2A5);

    // R12 register map
    wr(2'd2, 16'hFFFF); rd(2'd2, rv); check("R12 assign mask", rv, 16'h007B);
    wr(2'd1, 16'hFFFF); rd(2'd1, rv); check("R12 dir width", rv, 16'h07FF);

    // table walk over SPI mode/direction/assignment (R4 R5 R6 R7 R8 R9)
    @(negedge clk); pad_in = '1;
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd2, {9'd0, VEC[v][20:14]});
      wr(2'd1, {9'd0, VEC[v][13:7]});
      @(negedge clk); spi_en = VEC[v][22]; spi_master = VEC[v][21];
      #1;
      check($sformatf("R4/R5/R6/R9 vec%0d oe", v), pad_oe[6:0], VEC[v][6:0]);
    end
    check("R11 no fault during sweep", mode_fault, 0);

    // engine inputs, master
    wr(2'd2, 16'h007B); wr(2'd1, 16'h0000);
    @(negedge clk); spi_en = 1; spi_master = 1; #1;
    check("R4 miso_i follows pad", spi_miso_i, 1);
    check("R5 mosi_i master", spi_mosi_i, 0);
    check("R6 sck_o driven dir0", pad_out[2], 1);
    check("R7 ss_n_i master", spi_ss_n_i, 1);
    wr(2'd1, 16'h0001);
    check("R4 miso_i disabled", spi_miso_i, 0);
    wr(2'd1, 16'h0078);
    @(negedge clk); spi_pcs_o = 4'b1010; #1;
    check("R7 pcs0 out", pad_out[3], 0);
    check("R9 pcs out", pad_out[6:4], 3'b101);

    // engine inputs, slave
    wr(2'd1, 16'h0000);
    @(negedge clk); spi_master = 0; #1;
    check("R5 mosi_i slave", spi_mosi_i, 1);
    check("R6 sck_i slave", spi_sck_i, 1);
    @(negedge clk); pad_in[3] = 0; #1;
    check("R8 ss follows pad", spi_ss_n_i, 0);
    wr(2'd1, 16'h000A);
    check("R8 ss disabled", spi_ss_n_i, 1);
    check("R5 mosi_i disabled", spi_mosi_i, 0);
    edges(3);
    check("R11 no fault in slave", mode_fault, 0);

    // R11 mode fault timing, sticky, W1C; R7 dir1 blocks fault
    @(negedge clk); pad_in[3] = 1; spi_master = 1;
    wr(2'd1, 16'h0008);
    @(negedge clk); pad_in[3] = 0;
    edges(4);
    check("R7 dir1 no fault", mode_fault, 0);
    @(negedge clk); pad_in[3] = 1;
    wr(2'd1, 16'h0000);
    edges(3);
    @(negedge clk); pad_in[3] = 0;
    edges(2); check("R11 not yet", mode_fault, 0);
    edges(1); check("R11 set", mode_fault, 1);
    @(negedge clk); pad_in[3] = 1;
    edges(4); check("R11 sticky", mode_fault, 1);
    rd(2'd3, rv); check("R11 status read", rv, 1);
    wr(2'd3, 16'h0000); check("R11 write0 keeps", mode_fault, 1);
    wr(2'd3, 16'h0001); check("R11 cleared", mode_fault, 0);

    // R10 SCI pins
    @(negedge clk); spi_en = 0; pad_in[8] = 0;
    sci_tx_en = 2'b01; sci_txd = 2'b11; sci_rx_en = 2'b01; #1;
    check("R10 txd oe", pad_oe[7], 1);
    check("R10 txd out", pad_out[7], 1);
    check("R10 tx1 off", pad_oe[9], 0);
    check("R10 rxd0", sci_rxd, 2'b10);
    wr(2'd0, 16'h0100); wr(2'd1, 16'h0180);
    check("R10 rx en blocks oe", pad_oe[8], 0);
    @(negedge clk); sci_tx_en = 0; sci_rx_en = 0; #1;
    check("R10 gpio fallback oe", pad_oe[8:7], 2'b11);
    check("R10 gpio fallback out", pad_out[8:7], 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule